// File: doc/BRIEF.md
# Word-Count DMA Interface Controller

This block moves 16-bit words between system memory and an external parallel peripheral port without processor involvement per word. A host programs four 16-bit registers through a simple write strobe and reads them back combinationally: a word counter, a bus address, a control/status word and a data holding register. The counter is loaded with the negative of the number of words to move and climbs toward zero. The bus address is 18 bits wide; its upper two bits live in the control/status word.

On the write that sets the start bit, the block runs on its own. Toward the peripheral it alternates a memory read with an output handshake. From the peripheral it alternates an input handshake with a memory write. When the counter reaches zero it raises a ready flag and, if enabled, an interrupt. A memory error response stops the transfer with an error flag. A dedicated abort pattern written to the control/status word stops a transfer at once and raises an attention flag.

Top module: `wcdma_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irq`, `mem_req`, `pout_valid` and `pin_ready` are low.
- R2: The register is selected by `reg_addr[2:1]`: 0 word count, 1 address bits 15:0, 2 control/status, 3 data. Control/status bits: 15 error, 13 attention, 7 ready, 6 interrupt enable, 5:4 address bits 17:16, 3 wakeup, 1 direction (1 = peripheral to memory). Bit 0 is go and always reads 0. Unlisted bits read 0.
- R3: A control/status write with go set, made while idle with a nonzero count, starts a transfer. Direction 0 repeats a memory read (`mem_we`=0) followed by a `pout_valid`/`pout_ready` handshake carrying the word read. Direction 1 repeats a `pin_valid`/`pin_ready` handshake followed by a memory write (`mem_we`=1) of the word received.
- R4: Each completed word adds 2 to the 18-bit address, carrying into bits 17:16, and adds 1 to the count. When the count reaches 0 the transfer ends with ready set. Exactly the negated initial count of words is moved.
- R5: Starting with a count of 0 sets ready on the next cycle and issues no memory access.
- R6: A memory response with `mem_err` set on the granting cycle ends the transfer with both error and ready set. That word is not counted, and the count and address keep the values they had before it.
- R7: `irq` is high exactly while interrupt enable is set and ready or attention is set.
- R8: Any control/status write while idle clears error, ready and attention. Writing 0 therefore drops `irq`.
- R9: While a transfer runs, every register write other than the abort pattern is ignored, including a repeated go.
- R10: Writing control/status with bits 13, 6 and 3 all set while a transfer runs stops it on that edge. Attention is set, all handshake outputs go low, and the count and address hold their values.
- R11: A memory request keeps its address and write data stable until granted. `pout_data` stays stable while `pout_valid` waits for `pout_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host byte offset of the register |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 18 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_gnt | input | 1 | Memory grant; the access completes on this cycle |
| mem_err | input | 1 | Error response, valid with `mem_gnt` |
| mem_rdata | input | 16 | Memory read data, valid with `mem_gnt` |
| pout_valid | output | 1 | Word offered to the peripheral |
| pout_ready | input | 1 | Peripheral accepts the word |
| pout_data | output | 16 | Word to the peripheral |
| pin_valid | input | 1 | Peripheral offers a word |
| pin_ready | output | 1 | Block accepts a peripheral word |
| pin_data | input | 16 | Word from the peripheral |

## Verification
Seeded random transfers vary the direction, the length and the start address under random grant and handshake stalls. Matching memory and peripheral contents word for word shows that ordering and stall handling are right in both directions. One directed run starts just below a 64 KiB boundary, so the address carry can be told apart from plain 16-bit wrap. Other directed runs cover a zero count, injected memory errors in each direction, abort during a stall, a repeated go during a stall and a transfer with interrupts disabled. These separate the early-stop, ignore and flag-clearing paths from normal completion.

// File: rtl/wcdma_pkg.sv
package wcdma_pkg;
    localparam int REG_WC   = 0;
    localparam int REG_ADDR = 1;
    localparam int REG_CSR  = 2;
    localparam int REG_DATA = 3;
    localparam int NREG     = 4;

    localparam int B_ERR   = 15;
    localparam int B_ATTN  = 13;
    localparam int B_RDY   = 7;
    localparam int B_IE    = 6;
    localparam int B_EXT   = 4;
    localparam int B_WAKE  = 3;
    localparam int B_DIR   = 1;
    localparam int B_GO    = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PUSH,
        ST_PULL,
        ST_STORE
    } st_e;
endpackage

// File: rtl/wcdma_host_dec.sv
module wcdma_host_dec #(
    parameter int DW   = 16,
    parameter int NR   = 4,
    parameter int OFSW = 3
) (
    input  logic            we,
    input  logic [OFSW-1:0] ofs,
    input  logic [DW-1:0]   wdata,
    output logic [NR-1:0]   sel,
    output logic            go,
    output logic            abort_pat
);
    import wcdma_pkg::*;
    localparam int IW = OFSW - 1;

    for (genvar i = 0; i < NR; i++) begin : g_sel
        assign sel[i] = we && (ofs[OFSW-1:1] == IW'(i));
    end

    assign go        = wdata[B_GO];
    assign abort_pat = wdata[B_ATTN] && wdata[B_WAKE] && wdata[B_IE];

    logic unused_bit;
    assign unused_bit = ofs[0];
endmodule

// File: rtl/wcdma_step.sv
module wcdma_step #(
    parameter int DW = 16,
    parameter int AW = 18
) (
    input  logic [DW-1:0] wc,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] wc_next,
    output logic [AW-1:0] addr_next,
    output logic          last
);
    localparam int BYTES_PER_WORD = DW / 8;

    assign wc_next   = wc + DW'(1);
    assign addr_next = addr + AW'(BYTES_PER_WORD);
    assign last      = (wc_next == '0);
endmodule

// File: rtl/wcdma_ctrl.sv
module wcdma_ctrl #(
    parameter int DW = 16,
    parameter int XW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    output logic                 irq,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [DW+XW-1:0]     mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic                 mem_gnt,
    input  logic                 mem_err,
    input  logic [DW-1:0]        mem_rdata,
    output logic                 pout_valid,
    input  logic                 pout_ready,
    output logic [DW-1:0]        pout_data,
    input  logic                 pin_valid,
    output logic                 pin_ready,
    input  logic [DW-1:0]        pin_data
);
    import wcdma_pkg::*;

    localparam int AW   = DW + XW;
    localparam int OFSW = $clog2(NREG) + 1;

    typedef struct packed {
        st_e            state;
        logic [DW-1:0]  wc;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  data;
        logic           ie;
        logic           dir;
        logic           wake;
        logic           rdy;
        logic           err;
        logic           attn;
    } ctl_t;

    ctl_t q, d;

    logic [NREG-1:0] sel;
    logic            go_bit, abort_pat;
    logic [DW-1:0]   wc_inc;
    logic [AW-1:0]   addr_inc;
    logic            last_word;
    logic            busy;

    wcdma_host_dec #(.DW(DW), .NR(NREG), .OFSW(OFSW)) u_dec (
        .we        (reg_we),
        .ofs       (reg_addr),
        .wdata     (reg_wdata),
        .sel       (sel),
        .go        (go_bit),
        .abort_pat (abort_pat)
    );

    wcdma_step #(.DW(DW), .AW(AW)) u_step (
        .wc        (q.wc),
        .addr      (q.addr),
        .wc_next   (wc_inc),
        .addr_next (addr_inc),
        .last      (last_word)
    );

    assign busy       = (q.state != ST_IDLE);
    assign mem_req    = (q.state == ST_FETCH) || (q.state == ST_STORE);
    assign mem_we     = (q.state == ST_STORE);
    assign mem_addr   = q.addr;
    assign mem_wdata  = q.data;
    assign pout_valid = (q.state == ST_PUSH);
    assign pout_data  = q.data;
    assign pin_ready  = (q.state == ST_PULL);
    assign irq        = q.ie && (q.rdy || q.attn);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr[2:1])
            2'(REG_WC):   reg_rdata = q.wc;
            2'(REG_ADDR): reg_rdata = q.addr[DW-1:0];
            2'(REG_CSR): begin
                reg_rdata[B_ERR]          = q.err;
                reg_rdata[B_ATTN]         = q.attn;
                reg_rdata[B_RDY]          = q.rdy;
                reg_rdata[B_IE]           = q.ie;
                reg_rdata[B_EXT +: XW]    = q.addr[AW-1:DW];
                reg_rdata[B_WAKE]         = q.wake;
                reg_rdata[B_DIR]          = q.dir;
            end
            default:      reg_rdata = q.data;
        endcase
    end

    always_comb begin
        d = q;
        if (!busy) begin
            if (sel[REG_WC])   d.wc = reg_wdata;
            if (sel[REG_ADDR]) d.addr[DW-1:0] = reg_wdata;
            if (sel[REG_DATA]) d.data = reg_wdata;
            if (sel[REG_CSR]) begin
                d.ie             = reg_wdata[B_IE];
                d.dir            = reg_wdata[B_DIR];
                d.wake           = reg_wdata[B_WAKE];
                d.addr[AW-1:DW]  = reg_wdata[B_EXT +: XW];
                d.rdy            = 1'b0;
                d.err            = 1'b0;
                d.attn           = 1'b0;
                if (go_bit) begin
                    if (q.wc == '0)
                        d.rdy = 1'b1;
                    else
                        d.state = reg_wdata[B_DIR] ? ST_PULL : ST_FETCH;
                end
            end
        end else if (sel[REG_CSR] && abort_pat) begin
            d.state = ST_IDLE;
            d.attn  = 1'b1;
        end else begin
            case (q.state)
                ST_FETCH: if (mem_gnt) begin
                    if (mem_err) begin
                        d.err   = 1'b1;
                        d.rdy   = 1'b1;
                        d.state = ST_IDLE;
                    end else begin
                        d.data  = mem_rdata;
                        d.state = ST_PUSH;
                    end
                end
                ST_PUSH: if (pout_ready) begin
                    d.wc   = wc_inc;
                    d.addr = addr_inc;
                    if (last_word) begin
                        d.rdy   = 1'b1;
                        d.state = ST_IDLE;
                    end else begin
                        d.state = ST_FETCH;
                    end
                end
                ST_PULL: if (pin_valid) begin
                    d.data  = pin_data;
                    d.state = ST_STORE;
                end
                ST_STORE: if (mem_gnt) begin
                    if (mem_err) begin
                        d.err   = 1'b1;
                        d.rdy   = 1'b1;
                        d.state = ST_IDLE;
                    end else begin
                        d.wc   = wc_inc;
                        d.addr = addr_inc;
                        if (last_word) begin
                            d.rdy   = 1'b1;
                            d.state = ST_IDLE;
                        end else begin
                            d.state = ST_PULL;
                        end
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/wcdma_chk.sv
module wcdma_chk #(
    parameter int DW = 16,
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          irq,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_gnt,
    input logic          pout_valid,
    input logic          pout_ready,
    input logic [DW-1:0] pout_data,
    input logic          pin_valid,
    input logic          pin_ready,
    input logic [DW-1:0] pin_data
);
    logic csr_wr, abort_wr;
    assign csr_wr   = reg_we && (reg_addr[2:1] == 2'd2);
    assign abort_wr = csr_wr && reg_wdata[13] && reg_wdata[6] && reg_wdata[3];

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !abort_wr) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

    // R11
    pout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pout_valid && !pout_ready && !abort_wr) |=> (pout_valid && $stable(pout_data)));

    // R3
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, pout_valid, pin_ready}));

    // R3
    store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_ready && pin_valid && !abort_wr) |=>
            (mem_req && mem_we && mem_wdata == $past(pin_data)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pout_valid && pout_ready && !abort_wr) |=> (mem_addr == $past(mem_addr) + AW'(2)));

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && reg_wdata == '0) |=> !irq);

    // R10
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_wr && (mem_req || pout_valid || pin_ready)) |=>
            (!mem_req && !pout_valid && !pin_ready));
endmodule

bind wcdma_ctrl wcdma_chk #(.DW(DW), .AW(DW + XW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .irq        (irq),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_gnt    (mem_gnt),
    .pout_valid (pout_valid),
    .pout_ready (pout_ready),
    .pout_data  (pout_data),
    .pin_valid  (pin_valid),
    .pin_ready  (pin_ready),
    .pin_data   (pin_data)
);

// File: tb/wcdma_ctrl_bench.sv
module wcdma_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [17:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_err = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        pout_valid;
    logic        pout_ready = 1'b0;
    logic [15:0] pout_data;
    logic        pin_valid = 1'b0;
    logic        pin_ready;
    logic [15:0] pin_data = '0;

    always #5 clk = ~clk;

    wcdma_ctrl u_wcdma_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .pout_valid(pout_valid), .pout_ready(pout_ready),
        .pout_data(pout_data), .pin_valid(pin_valid), .pin_ready(pin_ready),
        .pin_data(pin_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int wd_bad = 0;
    bit done = 0;

    logic [15:0] mem [0:511];
    logic [15:0] src [0:63];
    logic [15:0] outl [0:63];
    logic [17:0] addr_log [0:63];
    int src_idx, out_cnt, acc_cnt, err_at;
    bit hold_in, hold_out;

    function automatic int widx(input logic [17:0] a);
        return int'(a[9:1]);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock step; the memory and peripheral models act at the falling edge
    task automatic tick();
        logic g;
        @(negedge clk);
        g = mem_req && ($urandom % 3 != 0);
        mem_gnt = g;
        mem_err = g && (acc_cnt == err_at);
        mem_rdata = mem[widx(mem_addr)];
        if (g) begin
            if (acc_cnt < 64) addr_log[acc_cnt] = mem_addr;
            if (!mem_err && mem_we) mem[widx(mem_addr)] = mem_wdata;
            acc_cnt++;
        end
        pout_ready = !hold_out && ($urandom % 2 == 0);
        if (pout_valid && pout_ready && out_cnt < 64) begin
            outl[out_cnt] = pout_data;
            out_cnt++;
        end
        pin_valid = !hold_in && src_idx < 64 && ($urandom % 2 == 0);
        pin_data = src[src_idx % 64];
        if (pin_valid && pin_ready) src_idx++;
    endtask

    task automatic wr(input int ofs, input logic [15:0] v);
        reg_we = 1'b1;
        reg_addr = 3'(ofs);
        reg_wdata = v;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input int ofs, output logic [15:0] v);
        reg_addr = 3'(ofs);
        #1;
        v = reg_rdata;
    endtask

    task automatic prep(input int n, input logic [17:0] start, input int e);
        for (int i = 0; i < 64; i++) src[i] = 16'($urandom);
        for (int i = 0; i < n; i++) mem[widx(start + 18'(2 * i))] = 16'($urandom);
        src_idx = 0; out_cnt = 0; acc_cnt = 0; err_at = e;
    endtask

    task automatic go(input bit dir, input int n, input logic [17:0] start, input bit ie);
        logic [15:0] c;
        c = 16'(ie) << 6 | 16'(start[17:16]) << 4 | 16'(dir) << 1;
        wr(0, 16'h0 - 16'(n));
        wr(2, start[15:0]);
        wr(4, c);
        wr(4, c | 16'h1);
    endtask

    task automatic wait_rdy(output bit irq_seen);
        logic [15:0] v;
        irq_seen = 0;
        for (int i = 0; i < 4000; i++) begin
            tick();
            if (irq) irq_seen = 1;
            rd(4, v);
            if (v[7]) break;
        end
    endtask

    task automatic run_ok(input string req, input bit dir, input int n,
                          input logic [17:0] start, input bit ie);
        logic [15:0] exp_mem [0:63];
        logic [15:0] v;
        logic [17:0] fin;
        bit seen;
        prep(n, start, -1);
        for (int i = 0; i < n; i++) exp_mem[i] = dir ? src[i] : mem[widx(start + 18'(2 * i))];
        go(dir, n, start, ie);
        wait_rdy(seen);
        tick();
        fin = start + 18'(2 * n);
        if (dir) begin
            chk({req, " words in"}, 32'(src_idx), 32'(n));
            for (int i = 0; i < n; i++)
                chk({req, " memory word"}, {16'h0, mem[widx(start + 18'(2 * i))]}, {16'h0, exp_mem[i]});
        end else begin
            chk({req, " words out"}, 32'(out_cnt), 32'(n));
            for (int i = 0; i < n && i < out_cnt; i++)
                chk({req, " peripheral word"}, {16'h0, outl[i]}, {16'h0, exp_mem[i]});
        end
        rd(0, v); chk({req, " R4 count zero"}, {16'h0, v}, 32'h0);
        rd(2, v); chk({req, " R4 final address"}, {16'h0, v}, {16'h0, fin[15:0]});
        rd(4, v);
        chk({req, " R2 csr"}, {16'h0, v},
            {16'h0, 16'h0080 | 16'(ie) << 6 | 16'(fin[17:16]) << 4 | 16'(dir) << 1});
        chk({req, " R7 irq"}, {31'h0, irq}, {31'h0, ie});
    endtask

    initial begin
        logic [15:0] v;
        bit seen;
        void'($urandom(32'd1234));
        hold_in = 0; hold_out = 0; err_at = -1; acc_cnt = 0; src_idx = 0; out_cnt = 0;
        for (int i = 0; i < 512; i++) mem[i] = 16'hDEAD;
        for (int i = 0; i < 64; i++) src[i] = 16'h0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        for (int r = 0; r < 4; r++) begin
            rd(2 * r, v);
            chk("R1 register reset", {16'h0, v}, 32'h0);
        end
        chk("R1 outputs idle", {28'h0, irq, mem_req, pout_valid, pin_ready}, 32'h0);

        // R2: data register readback at offset 6
        wr(6, 16'hA55A);
        rd(6, v); chk("R2 data register", {16'h0, v}, 32'hA55A);

        // R5: zero count
        prep(0, 18'h0, -1);
        wr(0, 16'h0);
        wr(4, 16'h0041);
        rd(4, v); chk("R5 ready after zero count", {16'h0, v}, 32'h00C0);
        chk("R5 no access", 32'(acc_cnt), 32'h0);
        chk("R7 irq on ready", {31'h0, irq}, 32'h1);
        // R8: clear by writing zero
        wr(4, 16'h0);
        chk("R8 irq dropped", {31'h0, irq}, 32'h0);
        rd(4, v); chk("R8 csr cleared", {16'h0, v}, 32'h0);

        // R3/R4: directed transfers in both directions
        run_ok("R3 dir0", 1'b0, 5, 18'h00040, 1'b1);
        run_ok("R3 dir1", 1'b1, 7, 18'h00100, 1'b1);

        // R4: address carry across 64 KiB
        prep(3, 18'h0FFFC, -1);
        go(1'b1, 3, 18'h0FFFC, 1'b1);
        wait_rdy(seen);
        chk("R4 carry addr 0", {14'h0, addr_log[0]}, 32'h0FFFC);
        chk("R4 carry addr 2", {14'h0, addr_log[2]}, 32'h10000);
        rd(2, v); chk("R4 carry low bits", {16'h0, v}, 32'h0002);
        rd(4, v); chk("R4 carry ext bits", {30'h0, v[5:4]}, 32'h1);

        // R7: interrupt disabled keeps irq low
        run_ok("R7 no ie", 1'b1, 3, 18'h00020, 1'b0);
        wr(4, 16'h0);

        // R6: read error on third access
        prep(5, 18'h00080, 2);
        go(1'b0, 5, 18'h00080, 1'b1);
        wait_rdy(seen);
        tick();
        chk("R6 words before error", 32'(out_cnt), 32'h2);
        rd(0, v); chk("R6 count held", {16'h0, v}, 32'h0000FFFD);
        rd(2, v); chk("R6 address held", {16'h0, v}, 32'h0084);
        rd(4, v); chk("R6 csr error", {16'h0, v}, 32'h80C0);
        wr(4, 16'h0);

        // R6: write error on second access
        prep(4, 18'h000C0, 1);
        mem[widx(18'h000C2)] = 16'hBEEF;
        go(1'b1, 4, 18'h000C0, 1'b1);
        wait_rdy(seen);
        chk("R6 first word stored", {16'h0, mem[widx(18'h000C0)]}, {16'h0, src[0]});
        chk("R6 failed word not stored", {16'h0, mem[widx(18'h000C2)]}, 32'hBEEF);
        rd(0, v); chk("R6 write count held", {16'h0, v}, 32'h0000FFFD);
        rd(2, v); chk("R6 write address held", {16'h0, v}, 32'h00C2);
        wr(4, 16'h0);

        // R9: go and register writes ignored while running
        prep(6, 18'h00140, -1);
        hold_out = 1;
        go(1'b0, 6, 18'h00140, 1'b1);
        repeat (10) tick();
        wr(0, 16'h0005);
        wr(2, 16'h1234);
        wr(4, 16'h0003);
        hold_out = 0;
        wait_rdy(seen);
        tick();
        chk("R9 all words moved", 32'(out_cnt), 32'h6);
        rd(0, v); chk("R9 count unaffected", {16'h0, v}, 32'h0);
        rd(2, v); chk("R9 address unaffected", {16'h0, v}, 32'h014C);
        rd(4, v); chk("R9 direction kept", {16'h0, v}, 32'h00C0);
        wr(4, 16'h0);

        // R10: abort while waiting for peripheral data
        prep(4, 18'h00180, -1);
        hold_in = 1;
        go(1'b1, 4, 18'h00180, 1'b1);
        repeat (5) tick();
        chk("R10 waiting for input", {31'h0, pin_ready}, 32'h1);
        wr(4, 16'h2048);
        chk("R10 outputs idle", {29'h0, mem_req, pout_valid, pin_ready}, 32'h0);
        chk("R10 irq on attention", {31'h0, irq}, 32'h1);
        rd(4, v); chk("R10 csr attention", {16'h0, v}, 32'h2042);
        rd(0, v); chk("R10 count held", {16'h0, v}, 32'h0000FFFC);
        rd(2, v); chk("R10 address held", {16'h0, v}, 32'h0180);
        hold_in = 0;
        repeat (4) tick();
        chk("R10 stays stopped", 32'(src_idx), 32'h0);
        wr(4, 16'h0);
        chk("R8 attention cleared", {31'h0, irq}, 32'h0);

        // random transfers
        for (int it = 0; it < 12; it++) begin
            bit dr;
            int n;
            logic [17:0] st;
            dr = 1'($urandom % 2);
            n = 1 + int'($urandom % 16);
            st = 18'(2 * ($urandom % 400));
            run_ok(dr ? "R3 random dir1" : "R3 random dir0", dr, n, st, 1'b1);
            wr(4, 16'h0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad + wd_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            wd_bad = 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + wd_bad);
            $finish;
        end
    end
endmodule